// File: doc/BRIEF.md
# Sticky Event Register with Masked Interrupt

This block gathers per-bit event conditions into two byte-wide sticky registers, an upper one of seven bits and a lower one of eight. Once a condition is seen, its bit stays set until the host clears it, so short pulses are never lost between polls. Alongside the sticky copy, the block keeps a live 16-bit status word. The status word shows each condition as it stands now and holds no history. Its top bit carries the present level of the interrupt pin.

The interrupt pin goes high when any enabled sticky bit is set, or when any enabled source in a separate group of summary sources is active. The enables sit in three mask registers: one for the upper events, one for the lower events and one for the summary group. A host reaches the registers through a plain byte-wide port with address, write data, read data and read and write strobes. A transaction-active input from the bus bridge tells the block when a host access is still in progress. Writing to either event register holds the interrupt low until that access ends. Without this hold, clearing one event while others stay pending would give a glitchy edge.

This is a control and status port with no data stream, so every pin is a plain level or strobe, with no valid/ready handshake. The host may issue a read or a write in any cycle.

Top module: `evt_irq_ctrl`

## Requirements
- R1: When a condition input bit is high at a clock edge, the matching sticky event bit is set after that edge. It stays set while there is no clearing write, even after the condition drops.
- R2: A write to an event register (address 0 for the upper seven events in bits 6:0, address 1 for the lower eight events) clears every event bit where the write data is 0. Bits written with 1 keep their value.
- R3: If a condition bit is high in the same cycle as a write that would clear that bit, the bit is set after the edge.
- R4: The status output bits 14:8 and 7:0 are a registered copy of the upper and lower condition inputs, updated at every edge. After reset, status bits 15:8 read 0011_1111b and bits 7:0 read 0.
- R5: Status bit 15 always equals the present level of the interrupt output.
- R6: The interrupt is high when any upper event bit is set with its bit set in the upper mask (address 2, bits 6:0), or when any lower event bit is set with its bit set in the lower mask (address 3, bits 7:0). This holds while no write hold is active.
- R7: The interrupt is also high when any summary source bit is high with its bit set in the summary mask (address 4, bits 3:0). This path is combinational from the source pins.
- R8: A write to address 0 or 1 forces the interrupt low from the next edge. The interrupt stays low until the first edge at which the transaction-active input is low and no new event-register write occurs. Writes to the mask registers do not force it low.
- R9: Reads of addresses 5 to 7 return 0. Unimplemented bits of the upper-event, upper-mask and summary-mask registers read 0.
- R10: Read data is registered. It presents the addressed register on the edge at which the read strobe is high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| txn_active | input | 1 | High while the current host transaction is open |
| ev_hi_in | input | 7 | Upper event condition inputs |
| ev_lo_in | input | 8 | Lower event condition inputs |
| sum_src | input | 4 | Summary source inputs |
| status | output | 16 | Live status: interrupt level in bit 15, conditions below it |
| irq | output | 1 | Interrupt output, active high |

## Verification
Each result has a fixed latency, and the bench drives every input just after a rising edge, then samples one delay step after the edge it waits for. Sticky bits, mask updates and the status copy take one edge, so they are checked right after the edge that captured the stimulus. Read data is checked right after the edge that carried the read strobe. The interrupt follows the summary sources with no edge in between, so it is checked one delay step after a source change. The write hold is checked on the edge after the event write, on each edge while the transaction stays open, and on the edge after it closes.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int HI_W   = DATA_W - 1;
  localparam int LO_W   = DATA_W;
  localparam int SUM_W  = 4;

  localparam logic [ADDR_W-1:0] A_EV_HI  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EV_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MK_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MK_LO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MK_SUM = 3'd4;
endpackage

// File: rtl/evt_bank.sv
module evt_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cond,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] ev_q
);
  logic [W-1:0] kept;

  always_comb begin
    kept = clr_we ? (ev_q & clr_data) : ev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= kept | cond;
  end

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((ev_q & $past(ev_q)) == $past(ev_q)));

  // R3
  cond_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond != '0) |=> ((ev_q & $past(cond)) == $past(cond)));
endmodule

// File: rtl/live_status.sv
module live_status #(
  parameter int               HI_W   = 7,
  parameter int               LO_W   = 8,
  parameter logic [HI_W-1:0]  HI_RST = 7'b011_1111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] hi_in,
  input  logic [LO_W-1:0] lo_in,
  output logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RST;
      lo_q <= '0;
    end else begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end
endmodule

// File: rtl/irq_gen.sv
module irq_gen #(
  parameter int HI_W  = 7,
  parameter int LO_W  = 8,
  parameter int SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HI_W-1:0]  ev_hi,
  input  logic [HI_W-1:0]  mk_hi,
  input  logic [LO_W-1:0]  ev_lo,
  input  logic [LO_W-1:0]  mk_lo,
  input  logic [SUM_W-1:0] sum_src,
  input  logic [SUM_W-1:0] mk_sum,
  input  logic             ev_wr,
  input  logic             txn_active,
  output logic             irq
);
  logic blank_q;
  logic any_hi, any_lo, any_sum;

  always_comb begin
    any_hi  = |(ev_hi & mk_hi);
    any_lo  = |(ev_lo & mk_lo);
    any_sum = |(sum_src & mk_sum);
    irq     = (any_hi | any_lo | any_sum) & ~blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blank_q <= 1'b0;
    else if (ev_wr)      blank_q <= 1'b1;
    else if (!txn_active) blank_q <= 1'b0;
  end

  // R8
  wr_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> !irq);

  // R8
  blank_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_q && txn_active) |=> !irq);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              txn_active,
  input  logic [HI_W-1:0]   ev_hi_in,
  input  logic [LO_W-1:0]   ev_lo_in,
  input  logic [SUM_W-1:0]  sum_src,
  output logic [2*DATA_W-1:0] status,
  output logic              irq
);
  localparam int HI_PAD  = DATA_W - HI_W;
  localparam int SUM_PAD = DATA_W - SUM_W;

  logic [HI_W-1:0]  ev_hi_q, mk_hi_q, st_hi_q;
  logic [LO_W-1:0]  ev_lo_q, mk_lo_q, st_lo_q;
  logic [SUM_W-1:0] mk_sum_q;
  logic             we_ev_hi, we_ev_lo;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  always_comb begin
    we_ev_hi = wr_en && (addr == A_EV_HI);
    we_ev_lo = wr_en && (addr == A_EV_LO);
  end

  evt_bank #(.W(HI_W)) u_ev_hi (
    .clk(clk), .rst_n(rst_n), .cond(ev_hi_in),
    .clr_we(we_ev_hi), .clr_data(wdata[HI_W-1:0]), .ev_q(ev_hi_q));

  evt_bank #(.W(LO_W)) u_ev_lo (
    .clk(clk), .rst_n(rst_n), .cond(ev_lo_in),
    .clr_we(we_ev_lo), .clr_data(wdata[LO_W-1:0]), .ev_q(ev_lo_q));

  live_status #(.HI_W(HI_W), .LO_W(LO_W), .HI_RST(7'b011_1111)) u_status (
    .clk(clk), .rst_n(rst_n), .hi_in(ev_hi_in), .lo_in(ev_lo_in),
    .hi_q(st_hi_q), .lo_q(st_lo_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_hi_q  <= '0;
      mk_lo_q  <= '0;
      mk_sum_q <= '0;
    end else if (wr_en) begin
      if (addr == A_MK_HI)  mk_hi_q  <= wdata[HI_W-1:0];
      if (addr == A_MK_LO)  mk_lo_q  <= wdata[LO_W-1:0];
      if (addr == A_MK_SUM) mk_sum_q <= wdata[SUM_W-1:0];
    end
  end

  irq_gen #(.HI_W(HI_W), .LO_W(LO_W), .SUM_W(SUM_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_hi(ev_hi_q), .mk_hi(mk_hi_q), .ev_lo(ev_lo_q), .mk_lo(mk_lo_q),
    .sum_src(sum_src), .mk_sum(mk_sum_q),
    .ev_wr(we_ev_hi | we_ev_lo), .txn_active(txn_active), .irq(irq));

  always_comb begin
    case (addr)
      A_EV_HI:  rd_mux = {{HI_PAD{1'b0}}, ev_hi_q};
      A_EV_LO:  rd_mux = ev_lo_q;
      A_MK_HI:  rd_mux = {{HI_PAD{1'b0}}, mk_hi_q};
      A_MK_LO:  rd_mux = mk_lo_q;
      A_MK_SUM: rd_mux = {{SUM_PAD{1'b0}}, mk_sum_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata  = rdata_q;
  assign status = {irq, st_hi_q, st_lo_q};

  // R9
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr > A_MK_SUM) |=> (rdata == '0));

  // R9
  pad_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == A_EV_HI || addr == A_MK_HI)) |=> !rdata[DATA_W-1]);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/evt_irq_ctrl_bench.sv
module evt_irq_ctrl_bench;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, txn_active = 1'b0;
  logic [7:0]  rdata;
  logic [6:0]  ev_hi_in = '0;
  logic [7:0]  ev_lo_in = '0;
  logic [3:0]  sum_src = '0;
  logic [15:0] status;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  evt_irq_ctrl u_evt_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .txn_active(txn_active),
    .ev_hi_in(ev_hi_in), .ev_lo_in(ev_lo_in), .sum_src(sum_src),
    .status(status), .irq(irq));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    check("R4 reset status", status, 16'h3F00);
    check("R5 reset irq", {15'd0, irq}, 16'd0);
    check("R10 reset rdata", {8'd0, rdata}, 16'd0);

    // R1 R2 R4: walk each event bit
    for (int i = 0; i < 15; i++) begin
      logic [14:0] v;
      v = 15'(1) << i;
      ev_hi_in = v[14:8]; ev_lo_in = v[7:0];
      tick();
      check("R4 live status set", {1'b0, status[14:0]}, {1'b0, v});
      ev_hi_in = '0; ev_lo_in = '0;
      tick();
      check("R4 live status drop", {1'b0, status[14:0]}, 16'd0);
      rd_reg(3'd0, d); check("R1 sticky hi", {8'd0, d}, {9'd0, v[14:8]});
      rd_reg(3'd1, d); check("R1 sticky lo", {8'd0, d}, {8'd0, v[7:0]});
      wr_reg(3'd0, 8'hFF); wr_reg(3'd1, 8'hFF);
      rd_reg(3'd0, d); check("R2 ones keep hi", {8'd0, d}, {9'd0, v[14:8]});
      rd_reg(3'd1, d); check("R2 ones keep lo", {8'd0, d}, {8'd0, v[7:0]});
      wr_reg(3'd0, ~{1'b0, v[14:8]}); wr_reg(3'd1, ~v[7:0]);
      rd_reg(3'd0, d); check("R2 zero clears hi", {8'd0, d}, 16'd0);
      rd_reg(3'd1, d); check("R2 zero clears lo", {8'd0, d}, 16'd0);
    end

    // R3: event in the same cycle as its clear
    ev_lo_in = 8'h10; addr = 3'd1; wdata = 8'h00; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; ev_lo_in = '0;
    rd_reg(3'd1, d); check("R3 event beats clear", {8'd0, d}, 16'h0010);
    wr_reg(3'd1, 8'h00);
    rd_reg(3'd1, d); check("R3 later clear works", {8'd0, d}, 16'd0);
    tick();

    // R6: lower mask sweep
    ev_lo_in = 8'hA5; tick(); ev_lo_in = '0;
    for (int m = 0; m < 256; m++) begin
      wr_reg(3'd3, 8'(m));
      check("R6 lo mask irq", {15'd0, irq}, {15'd0, |(8'hA5 & 8'(m))});
      check("R5 status irq bit", {15'd0, status[15]}, {15'd0, irq});
    end
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd1, 8'h00); tick();
    // R6: upper mask sweep
    ev_hi_in = 7'h2C; tick(); ev_hi_in = '0;
    for (int m = 0; m < 128; m++) begin
      wr_reg(3'd2, 8'(m));
      check("R6 hi mask irq", {15'd0, irq}, {15'd0, |(7'h2C & 7'(m))});
    end
    wr_reg(3'd2, 8'h00);
    wr_reg(3'd0, 8'h00); tick();

    // R7: summary source x mask sweep
    for (int m = 0; m < 16; m++) begin
      wr_reg(3'd4, 8'(m));
      for (int s = 0; s < 16; s++) begin
        sum_src = 4'(s); #1;
        check("R7 summary irq", {15'd0, irq}, {15'd0, |(4'(s) & 4'(m))});
      end
      sum_src = '0;
    end
    wr_reg(3'd4, 8'h00);

    // R8: write hold
    ev_lo_in = 8'h01; tick(); ev_lo_in = '0;
    wr_reg(3'd3, 8'h01);
    check("R8 irq before hold", {15'd0, irq}, 16'd1);
    txn_active = 1'b1;
    wr_reg(3'd2, 8'h00);
    check("R8 mask write no hold", {15'd0, irq}, 16'd1);
    wr_reg(3'd1, 8'hFF);
    check("R8 hold after event write", {15'd0, irq}, 16'd0);
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8 hold while open", {15'd0, irq}, 16'd0);
      check("R5 status irq low", {15'd0, status[15]}, 16'd0);
    end
    txn_active = 1'b0;
    tick();
    check("R8 release", {15'd0, irq}, 16'd1);
    check("R5 status irq high", {15'd0, status[15]}, 16'd1);

    // R9 R10
    for (int a = 5; a < 8; a++) begin
      rd_reg(3'(a), d); check("R9 unimplemented addr", {8'd0, d}, 16'd0);
    end
    wr_reg(3'd2, 8'hFF);
    rd_reg(3'd2, d); check("R9 hi mask pad bit", {8'd0, d}, 16'h007F);
    wr_reg(3'd4, 8'hFF);
    rd_reg(3'd4, d); check("R9 sum mask pad bits", {8'd0, d}, 16'h000F);
    wr_reg(3'd4, 8'h00);
    tick();
    check("R10 rdata held", {8'd0, rdata}, 16'h000F);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule